// File: doc/BRIEF.md
# Interrupt Channel Map Priority Router

This block sits after an interrupt source bank. It takes the vector of sources that are already enabled and pending. Each source passes through a byte-wide map entry that assigns it to one of 32 host channels. The block then finds the active channel with the smallest number. Channels 0 and 1 feed a fast interrupt output, and channels 2 to 31 feed a normal interrupt output. A global enable gates both outputs, and each output also has its own host enable.

Registers are written through a simple write port:

| Address | Function |
|---|---|
| 0 | Global enable |
| 1 | Host enable word |
| 2 | Host enable index set |
| 3 | Host enable index clear |
| 4 onward | Channel map words |

The block also reports the winning source and its channel. These outputs let the interrupt handler tell which source caused the request.

A small state machine registers the host outputs. Its states are:

| State | Meaning |
|---|---|
| ST_OFF | Global enable is clear |
| ST_IDLE | Enabled, but no gated group is active |
| ST_FAST | Only the fast output is asserted |
| ST_NORM | Only the normal output is asserted |
| ST_BOTH | Both outputs are asserted |

On every clock the machine moves to the state chosen by the gated group activity:

- Clearing the global enable moves it to ST_OFF from any state.
- With the global enable set, it goes to ST_IDLE, ST_FAST, ST_NORM or ST_BOTH, according to which gated groups are active.

Top module: `irq_route`

## Requirements
- R1: After reset both host outputs and `win_valid` are low, and the global enable and both host enables are 0. Every map byte resets to 0x0F, which places every source on channel 15.
- R2: Source number 4i+j takes its channel from bits [8j+7:8j] of the map word at address 4+i.
- R3: A map byte greater than 31 routes its source to channel 31.
- R4: `win_chan` gives the lowest-numbered channel that has at least one pending source. Channel 0 has the highest priority.
- R5: When several pending sources share the winning channel, `win_src` gives the lowest-numbered of those sources.
- R6: The fast output is high only while a pending source maps to channel 0 or 1 and host enable bit 0 is set. The normal output is high only while a pending source maps to a channel from 2 to 31 and host enable bit 1 is set.
- R7: Address 0, bit 0 holds the global enable. While this bit is 0, both host outputs are low whatever the pending sources.
- R8: Writing address 1 loads the host enables from data bits [1:0]. Bit 0 is the fast enable and bit 1 is the normal enable. Writing 0 disables both outputs.
- R9: Writing the value 0 or 1 to address 2 sets that host enable bit. Writing the same values to address 3 clears that bit. Any other written value leaves the host enables unchanged.
- R10: All outputs are registered. They reflect the inputs and register contents as they stood at the previous rising clock edge, so a change on `pend` appears one cycle later.
- R11: `win_valid` is high one cycle after any source is pending, whatever the enables. In that case `win_src` and `win_chan` describe the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend | input | NSRC | Enabled-and-pending source vector |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| irq_fast | output | 1 | Fast host interrupt (channels 0-1) |
| irq_norm | output | 1 | Normal host interrupt (channels 2-31) |
| win_valid | output | 1 | At least one source was pending |
| win_src | output | SRC_W | Index of the winning source |
| win_chan | output | 5 | Channel of the winning source |

## Verification
Some properties are checked on every cycle:

- Each host output follows its gated channel group with a delay of one cycle.
- A cleared global enable silences both outputs on the next cycle.
- An asserted fast output always comes with a winner on channel 0 or 1.
- Any pending source produces a valid winner.

Other behaviour can only be shown by the bench scenarios, because it depends on the contents of the map and the enable registers:

- the byte lanes used by the map,
- the clamp of large map values,
- the tie-break by lowest source number,
- which index values the set and clear registers ignore.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
    localparam int NCHAN  = 32;
    localparam int CH_W   = 5;
    localparam int NFAST  = 2;
    localparam int MAP_LO = 4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_FAST,
        ST_NORM,
        ST_BOTH
    } host_st_t;
endpackage

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NSRC   = 16,
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    output logic                   glob_en,
    output logic [1:0]             host_en,
    output logic [NSRC-1:0][7:0]   src_byte
);
    localparam int NMAP = (NSRC + 3) / 4;

    logic [NMAP-1:0][31:0] map_q;

    // global enable and host enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            host_en <= 2'b00;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_W'(0): glob_en <= wr_data[0];
                ADDR_W'(1): host_en <= wr_data[1:0];
                ADDR_W'(2): if (wr_data < 32'd2) host_en[wr_data[0]] <= 1'b1;
                ADDR_W'(3): if (wr_data < 32'd2) host_en[wr_data[0]] <= 1'b0;
                default: ;
            endcase
        end
    end

    // channel map words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NMAP; i++) map_q[i] <= 32'h0F0F_0F0F;
        end else if (wr_en) begin
            for (int i = 0; i < NMAP; i++) begin
                if (wr_addr == ADDR_W'(MAP_LO + i)) map_q[i] <= wr_data;
            end
        end
    end

    // byte lane j of word i belongs to source 4i+j
    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_lane
            assign src_byte[s] = map_q[s / 4][8 * (s % 4) +: 8];
        end
    endgenerate
endmodule

// File: rtl/irq_route_resolve.sv
`timescale 1ns/1ps
module irq_route_resolve
    import irq_route_pkg::*;
#(
    parameter int NSRC = 16,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]        pend,
    input  logic [NSRC-1:0][7:0]   src_byte,
    output logic [NCHAN-1:0]       chan_act,
    output logic                   any_act,
    output logic [SRC_W-1:0]       best_src,
    output logic [CH_W-1:0]        best_chan
);
    logic [NSRC-1:0][CH_W-1:0] src_chan;

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_clamp
            assign src_chan[s] = (src_byte[s] > 8'(NCHAN - 1)) ?
                                 CH_W'(NCHAN - 1) : src_byte[s][CH_W-1:0];
        end
    endgenerate

    always_comb begin
        chan_act = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (pend[s]) chan_act[src_chan[s]] = 1'b1;
        end
    end

    assign any_act = |pend;

    // lowest active channel wins
    always_comb begin
        best_chan = '0;
        for (int c = NCHAN - 1; c >= 0; c--) begin
            if (chan_act[c]) best_chan = CH_W'(c);
        end
    end

    // lowest source on that channel wins a tie
    always_comb begin
        best_src = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (pend[s] && src_chan[s] == best_chan) best_src = SRC_W'(s);
        end
    end
endmodule

// File: rtl/irq_route_host.sv
`timescale 1ns/1ps
module irq_route_host
    import irq_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       glob_en,
    input  logic [1:0] host_en,
    input  logic       fast_act,
    input  logic       norm_act,
    output logic       irq_fast,
    output logic       irq_norm
);
    host_st_t st_q, st_d;
    logic     go_fast, go_norm;

    assign go_fast = host_en[0] && fast_act;
    assign go_norm = host_en[1] && norm_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!glob_en) begin
            st_d = ST_OFF;
        end else begin
            unique case ({go_fast, go_norm})
                2'b00: st_d = ST_IDLE;
                2'b10: st_d = ST_FAST;
                2'b01: st_d = ST_NORM;
                2'b11: st_d = ST_BOTH;
                default: st_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        irq_fast = 1'b0;
        irq_norm = 1'b0;
        unique case (st_q)
            ST_OFF, ST_IDLE: ;
            ST_FAST: irq_fast = 1'b1;
            ST_NORM: irq_norm = 1'b1;
            ST_BOTH: begin
                irq_fast = 1'b1;
                irq_norm = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_route.sv
`timescale 1ns/1ps
module irq_route
    import irq_route_pkg::*;
#(
    parameter int NSRC   = 16,
    parameter int ADDR_W = 6,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   pend,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              irq_fast,
    output logic              irq_norm,
    output logic              win_valid,
    output logic [SRC_W-1:0]  win_src,
    output logic [CH_W-1:0]   win_chan
);
    logic                 glob_en;
    logic [1:0]           host_en;
    logic [NSRC-1:0][7:0] src_byte;
    logic [NCHAN-1:0]     chan_act;
    logic                 any_act;
    logic [SRC_W-1:0]     best_src;
    logic [CH_W-1:0]      best_chan;
    logic                 fast_act, norm_act;

    irq_route_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .glob_en(glob_en), .host_en(host_en),
        .src_byte(src_byte)
    );

    irq_route_resolve #(.NSRC(NSRC)) u_resolve (
        .pend(pend), .src_byte(src_byte), .chan_act(chan_act),
        .any_act(any_act), .best_src(best_src), .best_chan(best_chan)
    );

    assign fast_act = |chan_act[NFAST-1:0];
    assign norm_act = |chan_act[NCHAN-1:NFAST];

    irq_route_host u_host (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .host_en(host_en),
        .fast_act(fast_act), .norm_act(norm_act),
        .irq_fast(irq_fast), .irq_norm(irq_norm)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_src   <= '0;
            win_chan  <= '0;
        end else begin
            win_valid <= any_act;
            win_src   <= best_src;
            win_chan  <= best_chan;
        end
    end
endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int NSRC = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] pend,
    input logic            glob_en,
    input logic [1:0]      host_en,
    input logic            fast_act,
    input logic            norm_act,
    input logic            irq_fast,
    input logic            irq_norm,
    input logic            win_valid,
    input logic [CH_W-1:0] win_chan
);
    AST_GLOBAL_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (!irq_fast && !irq_norm)); // R7
    AST_FAST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && host_en[0] && fast_act) |=> irq_fast); // R6
    AST_FAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_act |=> !irq_fast); // R6
    AST_NORM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && host_en[1] && norm_act) |=> irq_norm); // R6
    AST_NORM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !norm_act |=> !irq_norm); // R6
    AST_FAST_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> (win_valid && win_chan < CH_W'(NFAST))); // R4
    AST_WIN_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |=> win_valid); // R11
endmodule

bind irq_route irq_route_chk #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .pend(pend), .glob_en(glob_en),
    .host_en(host_en), .fast_act(fast_act), .norm_act(norm_act),
    .irq_fast(irq_fast), .irq_norm(irq_norm), .win_valid(win_valid),
    .win_chan(win_chan)
);

// File: tb/irq_route_bench.sv
`timescale 1ns/1ps
module irq_route_bench;
    localparam int NSRC   = 16;
    localparam int ADDR_W = 6;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int NMAP   = (NSRC + 3) / 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   pend = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              irq_fast, irq_norm, win_valid;
    logic [SRC_W-1:0]  win_src;
    logic [4:0]        win_chan;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_byte [NSRC];
    logic       m_gen;
    logic [1:0] m_hen;

    always #10 clk = ~clk;

    irq_route #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_irq_route (
        .clk(clk), .rst_n(rst_n), .pend(pend), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq_fast(irq_fast),
        .irq_norm(irq_norm), .win_valid(win_valid), .win_src(win_src),
        .win_chan(win_chan)
    );

    function automatic logic [4:0] chan_of(logic [7:0] b);
        return (b > 8'd31) ? 5'd31 : b[4:0];
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        if (a == 0) m_gen = d[0];
        else if (a == 1) m_hen = d[1:0];
        else if (a == 2) begin if (d < 2) m_hen[d[0]] = 1'b1; end
        else if (a == 3) begin if (d < 2) m_hen[d[0]] = 1'b0; end
        else if (a >= 4 && a < 4 + NMAP) begin
            for (int j = 0; j < 4; j++)
                if (4 * (a - 4) + j < NSRC) m_byte[4 * (a - 4) + j] = d[8*j +: 8];
        end
    endtask

    // apply inputs for one cycle, check outputs after the edge
    task automatic cycle(string tag, logic [NSRC-1:0] p, logic we,
                         logic [ADDR_W-1:0] a, logic [31:0] d);
        logic [31:0] act;
        logic e_fast, e_norm;
        int e_chan, e_src;
        pend = p; wr_en = we; wr_addr = a; wr_data = d;
        act = '0;
        for (int s = 0; s < NSRC; s++) if (p[s]) act[chan_of(m_byte[s])] = 1'b1;
        e_fast = m_gen && m_hen[0] && (|act[1:0]);
        e_norm = m_gen && m_hen[1] && (|act[31:2]);
        e_chan = 0;
        for (int c = 31; c >= 0; c--) if (act[c]) e_chan = c;
        e_src = 0;
        for (int s = NSRC - 1; s >= 0; s--)
            if (p[s] && chan_of(m_byte[s]) == 5'(e_chan)) e_src = s;
        @(negedge clk);
        check(tag, "irq_fast", int'(irq_fast), int'(e_fast));
        check(tag, "irq_norm", int'(irq_norm), int'(e_norm));
        check(tag, "win_valid", int'(win_valid), int'(|p));
        if (|p) begin
            check(tag, "win_chan", int'(win_chan), e_chan);
            check(tag, "win_src", int'(win_src), e_src);
        end
        if (we) model_write(a, d);
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int s = 0; s < NSRC; s++) m_byte[s] = 8'h0F;
        m_gen = 1'b0; m_hen = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "irq_fast", int'(irq_fast), 0);
        check("R1", "irq_norm", int'(irq_norm), 0);
        check("R1", "win_valid", int'(win_valid), 0);
        // R1 default channel 15, R7 global off, R11 winner with no enables
        cycle("R1", 16'h0008, 1'b0, '0, '0);
        cycle("R7", 16'h0008, 1'b1, 6'd0, 32'd1);
        cycle("R9", 16'h0008, 1'b1, 6'd2, 32'd1);
        cycle("R6", 16'h0008, 1'b0, '0, '0);
        // R10: a new pending source is not visible before the edge
        pend = 16'h0000;
        @(negedge clk);
        pend = 16'h0040;
        #1;
        check("R10", "win_valid before edge", int'(win_valid), 0);
        // R2 map source 6 (word at 5, byte 2) to channel 1, source 4 and 5 on 15
        cycle("R2", 16'h0000, 1'b1, 6'd5, 32'h0F010F0F);
        cycle("R2", 16'h0048, 1'b0, '0, '0);
        cycle("R9", 16'h0048, 1'b1, 6'd2, 32'd0);
        cycle("R4", 16'h0048, 1'b0, '0, '0);
        // R5 tie between sources 4 and 5 on channel 15
        cycle("R5", 16'h0030, 1'b0, '0, '0);
        // R3 source 9 byte 0x40 -> channel 31
        cycle("R3", 16'h0000, 1'b1, 6'd6, 32'h0F0F400F);
        cycle("R3", 16'h0200, 1'b0, '0, '0);
        // R9 ignored index, R8 disable all, R7 global off
        cycle("R9", 16'h0248, 1'b1, 6'd2, 32'd5);
        cycle("R9", 16'h0248, 1'b1, 6'd3, 32'd7);
        cycle("R9", 16'h0248, 1'b0, '0, '0);
        cycle("R8", 16'h0248, 1'b1, 6'd1, 32'd0);
        cycle("R8", 16'h0248, 1'b1, 6'd1, 32'd3);
        cycle("R8", 16'h0248, 1'b0, '0, '0);
        cycle("R7", 16'h0248, 1'b1, 6'd0, 32'd0);
        cycle("R7", 16'h0248, 1'b0, '0, '0);
        cycle("R7", 16'h0248, 1'b1, 6'd0, 32'd1);
        // random phase
        for (int n = 0; n < 1500; n++) begin
            logic [NSRC-1:0] p;
            logic [ADDR_W-1:0] a;
            logic [31:0] d;
            logic we;
            p = NSRC'($urandom & $urandom & $urandom);
            we = ($urandom % 4) == 0;
            a = ADDR_W'($urandom % (4 + NMAP));
            if (a >= 4) d = $urandom & 32'h3F3F3F3F;
            else if (a == 0) d = 32'(($urandom % 5) != 0);
            else d = $urandom % 4;
            cycle("R4/R5/R6/R11", p, we, a, d);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule